// File: doc/BRIEF.md
# Write-Protect Unlock Sequencer

This block stands between the captured-write path of a byte-wide non-volatile memory and its page-write controller. The array is protected as a whole: no write cycle reaches the page buffer unless the host has first issued a fixed three-write command prefix. The sequencer watches every captured write cycle (a strobe with a 15-bit address and 8-bit data), steps through the prefix, and opens a write permit once the prefix is complete. Writes accepted under that permit are passed on, registered, to the page controller. Command writes and rejected writes are never passed on.

The prefix is, in order: data `AA` to address `5555`, data `55` to address `2AAA`, then data `A0` to address `5555` (hex). Every step has to arrive within the page-load window, as page bytes must. The page controller reports the end of that window with a one-cycle expiry pulse. When the pulse comes between command steps, the sequence is aborted. When it comes while the permit is open, internal programming has begun and the permit is withdrawn, so each new burst needs a fresh unlock.

Top module: `wp_unlock_seq`

## Requirements
- R1: After reset the permit is low and no write is forwarded.
- R2: The permit output goes high on the clock edge that samples the third command write. Before that, the writes (data `8'hAA`, address `15'h5555`), (data `8'h55`, address `15'h2AAA`) and (data `8'hA0`, address `15'h5555`) must have arrived in that order.
- R3: While the permit is high, each write strobe is forwarded one cycle later as a single-cycle valid pulse carrying the same address and data.
- R4: None of the three command writes is ever forwarded.
- R5: A write that does not match the expected command step returns the sequencer to idle, and that write is not forwarded.
- R6: An expiry pulse that arrives between command steps aborts the sequence, so a later completion of the remaining steps does not open the permit.
- R7: An expiry pulse while the permit is high drops the permit on the next edge. After that, writes are rejected until a full new prefix is given.
- R8: When an expiry pulse and a write strobe occur in the same cycle, the expiry wins and the write is not forwarded.
- R9: Writes given with no prefix are not forwarded.
- R10: After any abort, a complete correct prefix opens the permit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle strobe for a captured write cycle |
| wr_addr | input | 15 | Address of the captured write |
| wr_data | input | 8 | Data of the captured write |
| win_expired | input | 1 | Pulse from the page controller: the load window has ended |
| wr_permit | output | 1 | High while array writes are allowed |
| fwd_valid | output | 1 | Pulse: a permitted write is passed to the page controller |
| fwd_addr | output | 15 | Address of the forwarded write |
| fwd_data | output | 8 | Data of the forwarded write |

## Verification
The hardest cases to set up are the ones where the sequence is partly advanced and then disturbed. These include an expiry pulse after only the first command, and an expiry coinciding exactly with a data write under an open permit. Directed tasks place the expiry pulse and the strobe on chosen cycles. Each disturbance is followed by the rest of the prefix and a probe write, so an abort that failed to happen shows up as a forwarded probe or a raised permit.

// File: rtl/wp_unlock_pkg.sv
package wp_unlock_pkg;
  localparam int N_STEPS = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STEP1 = 2'd1,
    ST_STEP2 = 2'd2,
    ST_OPEN  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/wp_key_match.sv
module wp_key_match #(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter logic [AW-1:0] KEY_ADDR = '0,
  parameter logic [DW-1:0] KEY_DATA = '0
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          hit
);
  assign hit = (addr == KEY_ADDR) && (data == KEY_DATA);
endmodule

// File: rtl/wp_seq_fsm.sv
module wp_seq_fsm
  import wp_unlock_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_stb,
  input  logic [N_STEPS-1:0] step_hit,
  input  logic               win_expired,
  output logic               permit_q,
  output logic               accept
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    if (win_expired) begin
      state_d = ST_IDLE;
    end else if (wr_stb) begin
      case (state_q)
        ST_IDLE:  state_d = step_hit[0] ? ST_STEP1 : ST_IDLE;
        ST_STEP1: state_d = step_hit[1] ? ST_STEP2 : ST_IDLE;
        ST_STEP2: state_d = step_hit[2] ? ST_OPEN  : ST_IDLE;
        default: begin
          state_d = ST_OPEN;
          accept  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      permit_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      permit_q <= (state_d == ST_OPEN);
    end
  end

  // R7
  expiry_drops_permit_chk: assert property (@(posedge clk) disable iff (rst)
    win_expired |=> !permit_q);

  // R6
  expiry_mid_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (win_expired && state_q != ST_OPEN) |=> state_q == ST_IDLE);
endmodule

// File: rtl/wp_fwd_reg.sv
module wp_fwd_reg #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          fwd_valid,
  output logic [AW-1:0] fwd_addr,
  output logic [DW-1:0] fwd_data
);
  always_ff @(posedge clk) begin
    if (rst) fwd_valid <= 1'b0;
    else     fwd_valid <= accept;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      fwd_addr <= addr;
      fwd_data <= data;
    end
  end
endmodule

// File: rtl/wp_unlock_seq.sv
module wp_unlock_seq
  import wp_unlock_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter logic [N_STEPS*AW-1:0] KEY_ADDRS = {15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [N_STEPS*DW-1:0] KEY_DATAS = {8'hA0, 8'h55, 8'hAA}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          win_expired,
  output logic          wr_permit,
  output logic          fwd_valid,
  output logic [AW-1:0] fwd_addr,
  output logic [DW-1:0] fwd_data
);
  logic [N_STEPS-1:0] step_hit;
  logic               accept;

  for (genvar i = 0; i < N_STEPS; i++) begin : g_key
    wp_key_match #(
      .AW(AW), .DW(DW),
      .KEY_ADDR(KEY_ADDRS[i*AW +: AW]),
      .KEY_DATA(KEY_DATAS[i*DW +: DW])
    ) i_match (
      .addr(wr_addr), .data(wr_data), .hit(step_hit[i])
    );
  end

  wp_seq_fsm i_fsm (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .step_hit(step_hit),
    .win_expired(win_expired), .permit_q(wr_permit), .accept(accept)
  );

  wp_fwd_reg #(.AW(AW), .DW(DW)) i_fwd (
    .clk(clk), .rst(rst), .accept(accept), .addr(wr_addr), .data(wr_data),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_data(fwd_data)
  );

  // R3
  fwd_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_permit && !win_expired) |=>
      (fwd_valid && fwd_addr == $past(wr_addr) && fwd_data == $past(wr_data)));

  // R9
  fwd_needs_permit_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> $past(wr_permit));

  // R2
  permit_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_permit) |-> ($past(wr_stb) &&
      $past(wr_addr) == KEY_ADDRS[2*AW +: AW] &&
      $past(wr_data) == KEY_DATAS[2*DW +: DW]));

  // R8
  expiry_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (win_expired && wr_stb) |=> !fwd_valid);
endmodule

// File: tb/test_wp_unlock_seq.sv
`timescale 1ns/1ps
module test_wp_unlock_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_stb = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        win_expired = 1'b0;
  logic        wr_permit, fwd_valid;
  logic [14:0] fwd_addr;
  logic [7:0]  fwd_data;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wp_unlock_seq i_wp_unlock_seq (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .win_expired(win_expired), .wr_permit(wr_permit), .fwd_valid(fwd_valid),
    .fwd_addr(fwd_addr), .fwd_data(fwd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with outputs updated.
  task automatic wr(input logic [14:0] a, input logic [7:0] d, input bit exp_pulse = 1'b0);
    wr_stb = 1'b1; wr_addr = a; wr_data = d; win_expired = exp_pulse;
    @(negedge clk);
    wr_stb = 1'b0; win_expired = 1'b0;
  endtask

  task automatic expire();
    win_expired = 1'b1;
    @(negedge clk);
    win_expired = 1'b0;
  endtask

  task automatic unlock(input string req);
    wr(15'h5555, 8'hAA);
    check(fwd_valid == 1'b0, "R4", fwd_valid, 0);
    wr(15'h2AAA, 8'h55);
    check(fwd_valid == 1'b0, "R4", fwd_valid, 0);
    wr(15'h5555, 8'hA0);
    check(fwd_valid == 1'b0, "R4", fwd_valid, 0);
    check(wr_permit == 1'b1, req, wr_permit, 1);
  endtask

  task automatic probe_dropped(input string req);
    wr(15'h0123, 8'h3C);
    check(fwd_valid == 1'b0, req, fwd_valid, 0);
  endtask

  task automatic t_reset();
    check(wr_permit == 1'b0, "R1", wr_permit, 0);
    check(fwd_valid == 1'b0, "R1", fwd_valid, 0);
  endtask

  task automatic t_no_prefix();
    probe_dropped("R9");
    check(wr_permit == 1'b0, "R9", wr_permit, 0);
  endtask

  task automatic t_page_burst();
    unlock("R2");
    for (int k = 0; k < 4; k++) begin
      wr(15'h4A00 + 15'(k), 8'h10 + 8'(k));
      check(fwd_valid == 1'b1, "R3", fwd_valid, 1);
      check(fwd_addr == 15'h4A00 + 15'(k), "R3", fwd_addr, 15'h4A00 + k);
      check(fwd_data == 8'h10 + 8'(k), "R3", fwd_data, 8'h10 + k);
      @(negedge clk);
      check(fwd_valid == 1'b0, "R3", fwd_valid, 0);
    end
    expire();
    check(wr_permit == 1'b0, "R7", wr_permit, 1'b0);
    probe_dropped("R7");
  endtask

  task automatic t_bad_data();
    wr(15'h5555, 8'hAA);
    wr(15'h2AAA, 8'h56);
    check(fwd_valid == 1'b0, "R5", fwd_valid, 0);
    wr(15'h5555, 8'hA0);
    check(wr_permit == 1'b0, "R5", wr_permit, 0);
    probe_dropped("R5");
  endtask

  task automatic t_bad_addr();
    wr(15'h5555, 8'hAA);
    wr(15'h2AAA, 8'h55);
    wr(15'h5554, 8'hA0);
    check(wr_permit == 1'b0, "R5", wr_permit, 0);
    check(fwd_valid == 1'b0, "R5", fwd_valid, 0);
    unlock("R10");
    expire();
  endtask

  task automatic t_expire_mid();
    wr(15'h5555, 8'hAA);
    expire();
    wr(15'h2AAA, 8'h55);
    wr(15'h5555, 8'hA0);
    check(wr_permit == 1'b0, "R6", wr_permit, 0);
    probe_dropped("R6");
    unlock("R10");
    expire();
  endtask

  task automatic t_expire_collide();
    unlock("R2");
    wr(15'h4B07, 8'h99, 1'b1);
    check(fwd_valid == 1'b0, "R8", fwd_valid, 0);
    check(wr_permit == 1'b0, "R8", wr_permit, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_no_prefix();
    t_page_burst();
    t_bad_data();
    t_bad_addr();
    t_expire_mid();
    t_expire_collide();
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule